// File: doc/BRIEF.md
# Banked GPIO Controller with Latched or Transparent Pin Interrupts

This peripheral controls 32 general-purpose pins, arranged as four banks of eight. Each bank has its own 64-byte window on a simple synchronous register bus. The bus has an address, a write enable, write data, a read enable and registered read data.

For every pin, software chooses the direction and drives an output latch. Software also samples the pin level after a two-flop synchroniser.

Every pin also has interrupt logic that runs in one of two modes:
- **Transparent mode:** the status bit follows the synchronised level.
- **Latched (sticky) mode:** a high level sets the status bit, and the bit stays set until software clears it.

Masking is done with separate set and clear registers. Mode selection works the same way. All masked pending bits of all banks are OR-ed into one interrupt request.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every pin is an input (`pin_oe_o` all 0), every mask bit is 1, no pin is sticky, every status bit is 0 and `irq_o` is 0.
- R2: Address bits [7:6] select the bank and bits [5:0] select the register. Pin n is bank n>>3, bit n&7. Writes use `wdata_i[7:0]`. A read returns its byte zero-extended on `rdata_o` the cycle after `re_i`. `rdata_o` is 0 in any cycle that follows no read.
- R3: Offset 0x10 holds direction, where 1 means input; `pin_oe_o` is its inverse. Offset 0x14 holds the output latch, which drives `pin_o`. Both are plain read/write registers.
- R4: Offset 0x18 reads the pin levels after a two-flop synchroniser, so a pin change is visible in the third cycle.
- R5: A non-sticky pin's raw status bit equals its synchronised level, and drops as soon as that level is low.
- R6: A sticky pin's raw status bit is set by a high synchronised level and held until a 1 is written to that bit at offset 0x04. A clear wins over a simultaneous high level; the bit sets again one cycle later.
- R7: Writing 1s to offset 0x08 sets mask bits, and offset 0x08 reads the mask. Writing 1s to offset 0x0C clears mask bits, and offset 0x0C reads 0. Bits written 0 are unchanged.
- R8: Writing 1s to offset 0x20 makes pins sticky, and offset 0x20 reads the sticky bits. Writing 1s to offset 0x24 returns pins to transparent mode, and offset 0x24 reads 0. Leaving sticky mode discards the latched bit.
- R9: Offset 0x04 reads raw status. Offset 0x00 reads raw status AND NOT mask. `irq_o` is the OR of that masked status over all banks.
- R10: Writes to the read-only offsets 0x00 and 0x18 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address: bank in [7:6], offset in [5:0] |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data (low byte used) |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| pin_i | input | 32 | Pad input levels |
| pin_o | output | 32 | Output latch values |
| pin_oe_o | output | 32 | Output enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets four corner cases:
- **Clear while the pin is still high on a sticky pin.** A design that let the level win would never show the one-cycle drop. A design that ignored the level would lose the event.
- **Transparent-mode fall.** A latch kept alive here would hold `irq_o` after the pin falls.
- **Write-1-only semantics of the mask and mode registers.** A plain store would disturb the neighbouring bits.
- **Writes to read-only offsets and bank decoding.** A wrong slice would move effects into the wrong bank.

Random bus traffic and pin toggling cover interactions that the directed cases miss.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned OFF_W = 6;

  localparam logic [OFF_W-1:0] OFF_MSTAT   = 6'h00;
  localparam logic [OFF_W-1:0] OFF_RSTAT   = 6'h04;
  localparam logic [OFF_W-1:0] OFF_MASKSET = 6'h08;
  localparam logic [OFF_W-1:0] OFF_MASKCLR = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_DIR     = 6'h10;
  localparam logic [OFF_W-1:0] OFF_OUT     = 6'h14;
  localparam logic [OFF_W-1:0] OFF_IN      = 6'h18;
  localparam logic [OFF_W-1:0] OFF_STKSET  = 6'h20;
  localparam logic [OFF_W-1:0] OFF_STKCLR  = 6'h24;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned BANK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [BANK_W-1:0] wbyte_i,
  input  logic [BANK_W-1:0] lvl_i,
  output logic [BANK_W-1:0] raw_o,
  output logic [BANK_W-1:0] mask_o,
  output logic [BANK_W-1:0] dir_o,
  output logic [BANK_W-1:0] out_o,
  output logic [BANK_W-1:0] sticky_o
);
  logic [BANK_W-1:0] mask_q, dir_q, out_q, sticky_q, latch_q;
  logic [BANK_W-1:0] clr_vec;

  assign clr_vec = (wr_i && off_i == OFF_RSTAT) ? wbyte_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '1;
      dir_q    <= '1;
      out_q    <= '0;
      sticky_q <= '0;
    end else if (wr_i) begin
      unique case (off_i)
        OFF_MASKSET: mask_q   <= mask_q | wbyte_i;
        OFF_MASKCLR: mask_q   <= mask_q & ~wbyte_i;
        OFF_DIR:     dir_q    <= wbyte_i;
        OFF_OUT:     out_q    <= wbyte_i;
        OFF_STKSET:  sticky_q <= sticky_q | wbyte_i;
        OFF_STKCLR:  sticky_q <= sticky_q & ~wbyte_i;
        default: ;
      endcase
    end
  end

  // clear wins over a simultaneous level; the latch re-arms next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= '0;
    else         latch_q <= sticky_q & ~clr_vec & (latch_q | lvl_i);
  end

  assign raw_o    = (sticky_q & latch_q) | (~sticky_q & lvl_i);
  assign mask_o   = mask_q;
  assign dir_o    = dir_q;
  assign out_o    = out_q;
  assign sticky_o = sticky_q;

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(latch_q & sticky_q & ~clr_vec)) & ~latch_q) == '0)); // R6
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i == OFF_RSTAT) |=> ((latch_q & $past(wbyte_i)) == '0)); // R6
  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i == OFF_MASKSET) |=> ((mask_q & $past(wbyte_i)) == $past(wbyte_i))); // R7
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i == OFF_MASKCLR) |=> ((mask_q & $past(wbyte_i)) == '0)); // R7
  AST_STICKY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i == OFF_STKSET) |=> ((sticky_q & $past(wbyte_i)) == $past(wbyte_i))); // R8
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SYNC_STG  = 2,
  localparam int unsigned NUM_PINS = NUM_BANKS * BANK_W,
  localparam int unsigned SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned ADDR_W   = OFF_W + SEL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                re_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] lvl;
  logic [SEL_W-1:0]    sel;
  logic [OFF_W-1:0]    off;
  logic [BANK_W-1:0]   raw_b [NUM_BANKS];
  logic [BANK_W-1:0]   mask_b [NUM_BANKS];
  logic [BANK_W-1:0]   dir_b [NUM_BANKS];
  logic [BANK_W-1:0]   out_b [NUM_BANKS];
  logic [BANK_W-1:0]   stk_b [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_irq;
  logic [BANK_W-1:0]   rbyte;
  logic [DATA_W-1:0]   rdata_q;

  assign sel = addr_i[ADDR_W-1:OFF_W];
  assign off = addr_i[OFF_W-1:0];

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STG)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank #(.BANK_W(BANK_W)) i_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (we_i && sel == SEL_W'(b)),
      .off_i   (off),
      .wbyte_i (wdata_i[BANK_W-1:0]),
      .lvl_i   (lvl[b*BANK_W +: BANK_W]),
      .raw_o   (raw_b[b]),
      .mask_o  (mask_b[b]),
      .dir_o   (dir_b[b]),
      .out_o   (out_b[b]),
      .sticky_o(stk_b[b])
    );
    assign pin_o[b*BANK_W +: BANK_W]    = out_b[b];
    assign pin_oe_o[b*BANK_W +: BANK_W] = ~dir_b[b];
    assign bank_irq[b] = |(raw_b[b] & ~mask_b[b]);
  end

  always_comb begin
    rbyte = '0;
    unique case (off)
      OFF_MSTAT:   rbyte = raw_b[sel] & ~mask_b[sel];
      OFF_RSTAT:   rbyte = raw_b[sel];
      OFF_MASKSET: rbyte = mask_b[sel];
      OFF_DIR:     rbyte = dir_b[sel];
      OFF_OUT:     rbyte = out_b[sel];
      OFF_IN:      rbyte = lvl[sel*BANK_W +: BANK_W];
      OFF_STKSET:  rbyte = stk_b[sel];
      default:     rbyte = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= DATA_W'(rbyte);
    else           rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |bank_irq;

  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> (rdata_o == '0)); // R2
  AST_RDATA_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rdata_o[DATA_W-1:BANK_W] == '0)); // R2
endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  localparam int CLK_NS = 4;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [7:0]  addr_i = 0;
  logic        we_i = 0;
  logic [31:0] wdata_i = 0;
  logic        re_i = 0;
  logic [31:0] rdata_o;
  logic [31:0] pin_i = 0;
  logic [31:0] pin_o, pin_oe_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .re_i, .rdata_o,
    .pin_i, .pin_o, .pin_oe_o, .irq_o
  );

  // reference model
  logic [31:0] m_s1, m_s2, m_dir, m_out, m_mask, m_stk, m_lat, m_rd;

  function automatic logic [31:0] m_raw();
    logic [31:0] r;
    for (int p = 0; p < 32; p++) r[p] = m_stk[p] ? m_lat[p] : m_s2[p];
    return r;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_dir = '1; m_out = 0; m_mask = '1;
      m_stk = 0; m_lat = 0; m_rd = 0;
    end else begin
      logic [31:0] raw, nlat;
      int bk, base;
      logic [7:0] w;
      raw = m_raw();
      bk = int'(addr_i[7:6]);
      base = bk * 8;
      w = wdata_i[7:0];
      m_rd = 0;
      if (re_i) begin
        case (addr_i[5:0])
          6'h00: m_rd[7:0] = raw[base +: 8] & ~m_mask[base +: 8];
          6'h04: m_rd[7:0] = raw[base +: 8];
          6'h08: m_rd[7:0] = m_mask[base +: 8];
          6'h10: m_rd[7:0] = m_dir[base +: 8];
          6'h14: m_rd[7:0] = m_out[base +: 8];
          6'h18: m_rd[7:0] = m_s2[base +: 8];
          6'h20: m_rd[7:0] = m_stk[base +: 8];
          default: m_rd = 0;
        endcase
      end
      for (int p = 0; p < 32; p++) begin
        bit clr;
        clr = we_i && addr_i[5:0] == 6'h04 && (p / 8) == bk && w[p % 8];
        nlat[p] = m_stk[p] && !clr && (m_lat[p] || m_s2[p]);
      end
      m_lat = nlat;
      if (we_i) begin
        for (int i = 0; i < 8; i++) begin
          case (addr_i[5:0])
            6'h08: if (w[i]) m_mask[base+i] = 1;
            6'h0C: if (w[i]) m_mask[base+i] = 0;
            6'h10: m_dir[base+i] = w[i];
            6'h14: m_out[base+i] = w[i];
            6'h20: if (w[i]) m_stk[base+i] = 1;
            6'h24: if (w[i]) m_stk[base+i] = 0;
            default: ;
          endcase
        end
      end
      m_s2 = m_s1;
      m_s1 = pin_i;
    end
  end

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // cycle compare against model, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check(32'(irq_o), 32'(|(m_raw() & ~m_mask)), "R9 irq_o");
      check(rdata_o, m_rd, "R2 rdata_o");
      check(pin_o, m_out, "R3 pin_o");
      check(pin_oe_o, ~m_dir, "R3 pin_oe_o");
    end
  end

  task automatic wr(input int bank, input logic [5:0] off, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = {2'(bank), off}; wdata_i = {24'hA5A5A5, d}; we_i = 1; re_i = 0;
    @(negedge clk_i);
    we_i = 0;
  endtask

  task automatic rd_expect(input int bank, input logic [5:0] off, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    addr_i = {2'(bank), off}; re_i = 1; we_i = 0;
    @(negedge clk_i);
    re_i = 0;
    #1 check(rdata_o, {24'h0, exp}, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    #1 check(pin_oe_o, 32'h0, "R1 oe after reset");
    check(32'(irq_o), 0, "R1 irq after reset");
    rd_expect(0, 6'h08, 8'hFF, "R1 mask after reset");
    rd_expect(3, 6'h10, 8'hFF, "R1 dir after reset");
    rd_expect(2, 6'h20, 8'h00, "R1 sticky after reset");
    rd_expect(1, 6'h04, 8'h00, "R1 status after reset");

    // R3 direction/output, bank 1
    wr(1, 6'h10, 8'h0F);
    wr(1, 6'h14, 8'hA5);
    #1 check(pin_oe_o, 32'h0000_F000, "R3 oe bank1");
    check(pin_o, 32'h0000_A500, "R3 out bank1");
    rd_expect(1, 6'h14, 8'hA5, "R3 out readback");

    // R4 synchroniser latency: pin 26 = bank3 bit2
    @(negedge clk_i); pin_i[26] = 1;
    rd_expect(3, 6'h18, 8'h00, "R4 not yet visible");
    rd_expect(3, 6'h18, 8'h04, "R4 visible after sync");

    // R10 writes to read-only offsets
    wr(3, 6'h18, 8'h00);
    wr(3, 6'h00, 8'hFF);
    rd_expect(3, 6'h18, 8'h04, "R10 input unaffected");
    rd_expect(3, 6'h08, 8'hFF, "R10 mask unaffected");

    // R5 transparent: pin 3
    wr(0, 6'h0C, 8'h08);
    rd_expect(0, 6'h08, 8'hF7, "R7 unmask only bit3");
    @(negedge clk_i); pin_i[3] = 1;
    idle(3);
    #1 check(32'(irq_o), 1, "R5 transparent irq high");
    rd_expect(0, 6'h00, 8'h08, "R9 masked status");
    @(negedge clk_i); pin_i[3] = 0;
    idle(3);
    #1 check(32'(irq_o), 0, "R5 transparent irq dropped");
    rd_expect(0, 6'h0C, 8'h00, "R7 unmask reads zero");

    // R6/R8 sticky: pin 16 = bank2 bit0
    wr(2, 6'h20, 8'h01);
    rd_expect(2, 6'h20, 8'h01, "R8 sticky set");
    wr(2, 6'h0C, 8'h01);
    @(negedge clk_i); pin_i[16] = 1;
    @(negedge clk_i); pin_i[16] = 0;
    idle(4);
    rd_expect(2, 6'h04, 8'h01, "R6 latched after pulse");
    #1 check(32'(irq_o), 1, "R6 irq held");
    wr(2, 6'h04, 8'h01);
    #1 check(32'(irq_o), 0, "R6 cleared");
    // clear while high: drop for one cycle, then re-set
    @(negedge clk_i); pin_i[16] = 1;
    idle(3);
    @(negedge clk_i);
    addr_i = {2'd2, 6'h04}; wdata_i = 32'h1; we_i = 1;
    @(negedge clk_i);
    we_i = 0;
    #1 check(32'(irq_o), 0, "R6 clear wins");
    @(negedge clk_i);
    #1 check(32'(irq_o), 1, "R6 re-set next cycle");
    @(negedge clk_i); pin_i[16] = 0;
    wr(2, 6'h24, 8'h01);
    idle(3);
    rd_expect(2, 6'h04, 8'h00, "R8 leave sticky discards latch");
    rd_expect(2, 6'h24, 8'h00, "R8 clear reg reads zero");

    // R7 write-1 only
    wr(0, 6'h08, 8'h08);
    wr(0, 6'h0C, 8'h30);
    rd_expect(0, 6'h08, 8'hCF, "R7 mask bits independent");

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] offs [9] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h20, 6'h24};
      @(negedge clk_i);
      addr_i = {2'($urandom), offs[$urandom % 9]};
      wdata_i = $urandom;
      we_i = ($urandom % 3) == 0;
      re_i = !we_i && ($urandom % 2);
      if ($urandom % 4 == 0) pin_i = pin_i ^ (32'h1 << ($urandom % 32));
    end
    @(negedge clk_i); we_i = 0; re_i = 0;
    idle(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule